// File: doc/BRIEF.md
# Shared Byte Memory with Cross-Port Mailbox Interrupts

Two 8-bit processors share one 2048-byte memory. Each processor has its own port: an 11-bit offset, write data, a chip select, and read and write strobes. Both ports can use the memory in the same clock cycle. A read returns its data on the clock edge that samples the request, so it has one cycle of latency. Between reads, the read data output holds its last value.

The two highest offsets are mailboxes, one for each direction. The left port writes offset 0x7FF to send a byte to the right. That write also raises the right port's interrupt. The right port reads offset 0x7FF to collect the byte, and that read clears the request. Offset 0x7FE carries bytes the other way: the right port writes it to reach the left port, and the left port reads it. Every other offset is plain shared storage.

Each interrupt is a two-state machine. FLAG_IDLE drives the active-low request output high. FLAG_PENDING drives it low. The machine has three transitions:
- IDLE to PENDING when the sending side writes its mailbox.
- PENDING to IDLE when the receiving side reads that mailbox and no new write arrives in the same cycle.
- PENDING to PENDING when a new write arrives in the same cycle as a clearing read.

Reset puts both machines in FLAG_IDLE. Address mirroring across a larger processor window is left to the logic outside this block.

Top module: `mbox_dpram`

## Requirements
- R1: A byte written at any offset through either port is returned by a later read of that offset through either port. The read data appears on the clock edge that samples the read. It holds its value while that port does not read.
- R2: A left-port write to offset 0x7FF stores the byte and drives r_irq_n low from the next cycle.
- R3: A right-port read of offset 0x7FF returns the byte the left port stored there and drives r_irq_n high from the next cycle.
- R4: A right-port write to offset 0x7FE stores the byte and drives l_irq_n low from the next cycle.
- R5: A left-port read of offset 0x7FE returns the byte the right port stored there and drives l_irq_n high from the next cycle.
- R6: After reset, both l_irq_n and r_irq_n are high and both read data outputs are 0x00.
- R7: Reads and writes at offsets below 0x7FE leave both interrupt outputs unchanged.
- R8: When both ports write the same offset in the same cycle, the stored byte is the left port's.
- R9: When a flag-setting write and a read of the same mailbox occur in one cycle, the read returns the byte held before that write, and the interrupt stays asserted (low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | 11 | Left port byte offset |
| l_wdata | input | 8 | Left port write data |
| l_cs | input | 1 | Left port chip select |
| l_rd | input | 1 | Left port read strobe |
| l_wr | input | 1 | Left port write strobe |
| l_rdata | output | 8 | Left port registered read data |
| l_irq_n | output | 1 | Interrupt toward the left processor, active low |
| r_addr | input | 11 | Right port byte offset |
| r_wdata | input | 8 | Right port write data |
| r_cs | input | 1 | Right port chip select |
| r_rd | input | 1 | Right port read strobe |
| r_wr | input | 1 | Right port write strobe |
| r_rdata | output | 8 | Right port registered read data |
| r_irq_n | output | 1 | Interrupt toward the right processor, active low |

## Verification
The bench drives both ports to write one offset in the same cycle and checks that the left byte is stored. A design that let the later process win would return the right byte. It also issues a mailbox write and a mailbox read together. A design that forwarded new data would return the fresh byte, and one that let the clear win would release the interrupt too early. The bench writes offset 0x7FD, one below the lower mailbox, and reads ordinary offsets. A decoder that matched too few address bits would raise a request there. Each interrupt is checked in the cycle after its trigger, and again after a clearing read on an idle flag.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/dpmb_mem.sv
module dpmb_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Port a is written last, so it wins a same-offset collision (R8).
    always_ff @(posedge clk) begin
        if (b_we) begin
            cells[b_addr] <= b_wdata;
        end
        if (a_we) begin
            cells[a_addr] <= a_wdata;
        end
    end

    // Registered reads return the contents before this cycle's writes (R9).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_re) begin
                a_rdata <= cells[a_addr];
            end
            if (b_re) begin
                b_rdata <= cells[b_addr];
            end
        end
    end

    assert_a_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> $stable(a_rdata));
    assert_b_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> $stable(b_rdata));
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag
    import dpmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_i) begin
                    state_d = FLAG_PENDING;
                end
            end
            FLAG_PENDING: begin
                if (clr_i && !set_i) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        irq_n_o = (state_q != FLAG_PENDING);
    end

    assert_set_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n_o);
    assert_clear_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n_o);
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> !irq_n_o);
    assert_quiet_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_cs,
    input  logic              l_rd,
    input  logic              l_wr,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_cs,
    input  logic              r_rd,
    input  logic              r_wr,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BOX_TO_R = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] BOX_TO_L = ADDR_W'(DEPTH - 2);

    logic l_we, l_re, r_we, r_re;
    logic raise_r, drop_r, raise_l, drop_l;

    always_comb begin
        l_we    = l_cs && l_wr;
        l_re    = l_cs && l_rd;
        r_we    = r_cs && r_wr;
        r_re    = r_cs && r_rd;
        raise_r = l_we && (l_addr == BOX_TO_R);
        drop_r  = r_re && (r_addr == BOX_TO_R);
        raise_l = r_we && (r_addr == BOX_TO_L);
        drop_l  = l_re && (l_addr == BOX_TO_L);
    end

    dpmb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_we   (l_we),
        .a_re   (l_re),
        .a_addr (l_addr),
        .a_wdata(l_wdata),
        .a_rdata(l_rdata),
        .b_we   (r_we),
        .b_re   (r_re),
        .b_addr (r_addr),
        .b_wdata(r_wdata),
        .b_rdata(r_rdata)
    );

    dpmb_flag u_flag_r (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (raise_r),
        .clr_i  (drop_r),
        .irq_n_o(r_irq_n)
    );

    dpmb_flag u_flag_l (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (raise_l),
        .clr_i  (drop_l),
        .irq_n_o(l_irq_n)
    );

    assert_plain_no_left_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(r_cs && r_wr && r_addr == BOX_TO_L) && !(l_cs && l_rd && l_addr == BOX_TO_L))
        |=> $stable(l_irq_n));
    assert_plain_no_right_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(l_cs && l_wr && l_addr == BOX_TO_R) && !(r_cs && r_rd && r_addr == BOX_TO_R))
        |=> $stable(r_irq_n));
endmodule

// File: tb/mbox_dpram_tb.sv
`timescale 1ns/1ps
module mbox_dpram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] l_addr = '0, r_addr = '0;
    logic [7:0]  l_wdata = '0, r_wdata = '0;
    logic        l_cs = 0, l_rd = 0, l_wr = 0, r_cs = 0, r_rd = 0, r_wr = 0;
    logic [7:0]  l_rdata, r_rdata;
    logic        l_irq_n, r_irq_n;

    typedef struct {
        bit         right;
        logic [7:0] data;
        int         stamp;
        string      tag;
    } exp_t;

    exp_t       q[$];
    logic [7:0] model [2048];
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mbox_dpram u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_cs(l_cs), .l_rd(l_rd), .l_wr(l_wr),
        .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_cs(r_cs), .r_rd(r_rd), .r_wr(r_wr),
        .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares read results pushed in an earlier cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp < cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.right ? r_rdata : l_rdata, e.data, e.tag);
        end
    end

    task automatic op(input bit lc, input bit lr, input bit lw, input logic [10:0] la,
                      input logic [7:0] ld, input bit rc, input bit rr, input bit rw,
                      input logic [10:0] ra, input logic [7:0] rd, input string tag);
        @(negedge clk);
        l_cs = lc; l_rd = lr; l_wr = lw; l_addr = la; l_wdata = ld;
        r_cs = rc; r_rd = rr; r_wr = rw; r_addr = ra; r_wdata = rd;
        if (lc && lr) q.push_back('{1'b0, model[la], cyc, tag});
        if (rc && rr) q.push_back('{1'b1, model[ra], cyc, tag});
        if (rc && rw) model[ra] = rd;
        if (lc && lw) model[la] = ld;
    endtask

    task automatic idle();
        op(0, 0, 0, '0, '0, 0, 0, 0, '0, '0, "idle");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check({7'd0, l_irq_n}, 8'h01, "R6 l_irq_n reset");
        check({7'd0, r_irq_n}, 8'h01, "R6 r_irq_n reset");
        check(l_rdata, 8'h00, "R6 l_rdata reset");
        check(r_rdata, 8'h00, "R6 r_rdata reset");
        rst_n = 1'b1;
        // Clear the locations used below so the model matches the array.
        op(1, 0, 1, 11'h005, 8'h00, 1, 0, 1, 11'h123, 8'h00, "init");
        op(1, 0, 1, 11'h040, 8'h00, 1, 0, 1, 11'h7FD, 8'h00, "init");
        op(1, 0, 1, 11'h7FF, 8'h00, 0, 0, 0, '0, '0, "init");
        op(0, 0, 0, '0, '0, 1, 0, 1, 11'h7FE, 8'h00, "init");
        op(1, 1, 0, 11'h7FE, '0, 1, 1, 0, 11'h7FF, '0, "init");
        idle();
        check({7'd0, l_irq_n}, 8'h01, "init l_irq_n");
        check({7'd0, r_irq_n}, 8'h01, "init r_irq_n");

        // R1 plain storage, both ports, cross reads
        op(1, 0, 1, 11'h005, 8'hA5, 1, 0, 1, 11'h123, 8'h3C, "R1 write");
        op(1, 1, 0, 11'h123, '0, 1, 1, 0, 11'h005, '0, "R1 cross read");
        idle();
        check(l_rdata, 8'h3C, "R1 l_rdata hold");
        // R7 boundary offset 0x7FD and ordinary reads
        op(1, 0, 1, 11'h7FD, 8'h99, 1, 1, 0, 11'h7FD, '0, "R7 old 0x7FD");
        op(1, 1, 0, 11'h7FD, '0, 1, 0, 1, 11'h000, 8'h11, "R7 read 0x7FD");
        idle();
        check({7'd0, l_irq_n}, 8'h01, "R7 l_irq_n");
        check({7'd0, r_irq_n}, 8'h01, "R7 r_irq_n");

        // R8 collision
        op(1, 0, 1, 11'h040, 8'hE1, 1, 0, 1, 11'h040, 8'h1E, "R8 collide");
        op(0, 0, 0, '0, '0, 1, 1, 0, 11'h040, '0, "R8 left wins");

        // R2 left to right mailbox
        op(1, 0, 1, 11'h7FF, 8'h5A, 0, 0, 0, '0, '0, "R2 write");
        idle();
        check({7'd0, r_irq_n}, 8'h00, "R2 r_irq_n low");
        check({7'd0, l_irq_n}, 8'h01, "R2 l_irq_n stays high");

        // R9 write and read of mailbox together
        op(1, 0, 1, 11'h7FF, 8'h77, 1, 1, 0, 11'h7FF, '0, "R9 old data");
        idle();
        check({7'd0, r_irq_n}, 8'h00, "R9 r_irq_n held low");

        // R3 receiving read
        op(0, 0, 0, '0, '0, 1, 1, 0, 11'h7FF, '0, "R3 data");
        idle();
        check({7'd0, r_irq_n}, 8'h01, "R3 r_irq_n released");

        // R4 right to left mailbox
        op(0, 0, 0, '0, '0, 1, 0, 1, 11'h7FE, 8'hC3, "R4 write");
        idle();
        check({7'd0, l_irq_n}, 8'h00, "R4 l_irq_n low");
        check({7'd0, r_irq_n}, 8'h01, "R4 r_irq_n stays high");

        // R5 receiving read
        op(1, 1, 0, 11'h7FE, '0, 0, 0, 0, '0, '0, "R5 data");
        idle();
        check({7'd0, l_irq_n}, 8'h01, "R5 l_irq_n released");

        // R5 clearing read on idle flag keeps it idle
        op(1, 1, 0, 11'h7FE, '0, 1, 1, 0, 11'h7FF, '0, "R5 reread");
        idle();
        check({7'd0, l_irq_n}, 8'h01, "R5 idle l_irq_n");
        check({7'd0, r_irq_n}, 8'h01, "R3 idle r_irq_n");

        idle();
        idle();
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R1: actual=%0d expected=0 pending reads", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule